// File: doc/BRIEF.md
# Strobed Handshake Output Port

This block is one 8-bit output channel with a two-wire handshake toward a peripheral. A processor writes a byte through a select, write strobe and small address bus. The byte is latched onto the port pins and stays there. At the same time an active-low "buffer full" flag drops to tell the peripheral that fresh data is waiting. The peripheral takes the byte and answers with a low-going acknowledge. That acknowledge releases the flag. If the interrupt enable is on, the release also raises an interrupt request, so the processor knows the channel can take its next byte.

The interrupt enable has no pin of its own. It is changed with single-bit set/clear commands written to a command offset. The same command form also drives two spare general-purpose output bits that this mode leaves free. The acknowledge input is asynchronous and passes through a synchronizer of configurable depth before its falling edge is detected.

Top module: `ppo_strobed_out`

## Requirements
- R1: After reset, `pdata` is 0, `obf_n` is 1, `intr` is 0, `gp_out` is 0 and the interrupt enable is 0.
- R2: A write (`cs`=1, `wr`=1) at offset 0 loads `wdata` onto `pdata` at the next clock edge, and `pdata` keeps that value until the next such write.
- R3: A write at offset 0 drives `obf_n` to 0 at the next clock edge.
- R4: A falling edge on `ack_n` drives `obf_n` back to 1. The edge takes effect SYNC_STAGES clock edges after the first edge that samples `ack_n` low.
- R5: An acknowledge that arrives while `obf_n` is already 1 changes nothing: `obf_n` stays 1 and `intr` is not set.
- R6: An acknowledge that releases `obf_n` sets `intr` when the interrupt enable is 1, and leaves `intr` at 0 when it is 0.
- R7: A write at offset 0 clears `intr`. Clearing the interrupt enable also clears `intr` one cycle later.
- R8: A write at offset 3 with `wdata[7]`=0 is a bit command. `wdata[3:1]` selects the bit and `wdata[0]` gives its new value. Bit IE_BIT (6) is the interrupt enable, bit GP_BIT0 (4) is `gp_out[0]` and bit GP_BIT0+1 (5) is `gp_out[1]`. Other bit numbers change nothing, and an offset-3 write with `wdata[7]`=1 is ignored.
- R9: When a data write and a released acknowledge fall on the same clock edge, the write wins: `obf_n` stays 0, `intr` is 0 and `pdata` takes the new byte.
- R10: Writes with `cs`=0, and writes to offsets 1 or 2, change no output and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Block select |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register offset (0 data, 3 bit command) |
| wdata | input | DW | Write data |
| ack_n | input | 1 | Asynchronous active-low acknowledge from peripheral |
| pdata | output | DW | Latched output data to peripheral |
| obf_n | output | 1 | Active-low output buffer full |
| intr | output | 1 | Interrupt request |
| gp_out | output | 2 | General-purpose spare bits |

## Verification
A wrong interrupt-enable value has no pin of its own. It shows up only on the next acknowledge, as `intr` set or not set, so every bit command is followed by a write and acknowledge round before it is judged. A stuck or missing buffer-full state shows on `obf_n` within one edge of a write. An acknowledge path that is wrong, slow or that double-fires shows up SYNC_STAGES edges after `ack_n` falls, in `obf_n` and `intr`. The collision case puts a write exactly on the acknowledge edge, which exposes a wrong priority order in the same cycle.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd3;

  typedef struct packed {
    logic       valid;
    logic [2:0] idx;
    logic       val;
  } bitcmd_t;

  function automatic bitcmd_t decode_bitcmd(input logic [7:0] d);
    bitcmd_t c;
    c.valid = ~d[7];
    c.idx   = d[3:1];
    c.val   = d[0];
    return c;
  endfunction
endpackage

// File: rtl/ppo_ack_sync.sv
module ppo_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic ack_ev
);
  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b1;
        else     sh[0] <= ack_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b1;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sh[STAGES-1];
  end

  assign ack_ev = prev & ~sh[STAGES-1];
endmodule

// File: rtl/ppo_ctl_bits.sv
module ppo_ctl_bits
  import ppo_pkg::*;
#(
  parameter int IE_BIT  = 6,
  parameter int GP_BIT0 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_ev,
  input  logic [7:0] cmd_byte,
  output logic       ie,
  output logic [1:0] gp
);
  localparam logic [2:0] IE_IDX = 3'(IE_BIT);
  localparam logic [2:0] GP_IDX0 = 3'(GP_BIT0);
  localparam logic [2:0] GP_IDX1 = 3'(GP_BIT0 + 1);

  bitcmd_t c;
  assign c = decode_bitcmd(cmd_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0;
      gp <= 2'b00;
    end else if (cmd_ev && c.valid) begin
      if (c.idx == IE_IDX)  ie    <= c.val;
      if (c.idx == GP_IDX0) gp[0] <= c.val;
      if (c.idx == GP_IDX1) gp[1] <= c.val;
    end
  end
endmodule

// File: rtl/ppo_handshake.sv
module ppo_handshake (
  input  logic clk,
  input  logic rst,
  input  logic wr_data_ev,
  input  logic ack_ev,
  input  logic ie,
  output logic obf_n,
  output logic intr
);
  always_ff @(posedge clk) begin
    if (rst)             obf_n <= 1'b1;
    else if (wr_data_ev) obf_n <= 1'b0;
    else if (ack_ev)     obf_n <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  intr <= 1'b0;
    else if (wr_data_ev)      intr <= 1'b0;
    else if (!ie)             intr <= 1'b0;
    else if (ack_ev && !obf_n) intr <= 1'b1;
  end
endmodule

// File: rtl/ppo_strobed_out.sv
module ppo_strobed_out
  import ppo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IE_BIT      = 6,
  parameter int GP_BIT0     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_n,
  output logic [DW-1:0] pdata,
  output logic          obf_n,
  output logic          intr,
  output logic [1:0]    gp_out
);
  logic wr_data_ev;
  logic bit_cmd_ev;
  logic ack_ev;
  logic ie_q;

  assign wr_data_ev = cs & wr & (addr == OFS_DATA);
  assign bit_cmd_ev = cs & wr & (addr == OFS_CMD);

  always_ff @(posedge clk) begin
    if (rst)             pdata <= '0;
    else if (wr_data_ev) pdata <= wdata;
  end

  ppo_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n(ack_n), .ack_ev(ack_ev)
  );

  ppo_ctl_bits #(.IE_BIT(IE_BIT), .GP_BIT0(GP_BIT0)) u_ctl (
    .clk(clk), .rst(rst), .cmd_ev(bit_cmd_ev), .cmd_byte(wdata[7:0]),
    .ie(ie_q), .gp(gp_out)
  );

  ppo_handshake u_hs (
    .clk(clk), .rst(rst), .wr_data_ev(wr_data_ev), .ack_ev(ack_ev),
    .ie(ie_q), .obf_n(obf_n), .intr(intr)
  );
endmodule

// File: rtl/ppo_strobed_out_chk.sv
module ppo_strobed_out_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_data_ev,
  input logic          bit_cmd_ev,
  input logic          ack_ev,
  input logic          ie_q,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] pdata,
  input logic          obf_n,
  input logic          intr
);
  a_r2_data_latched: assert property (@(posedge clk) disable iff (rst)
    wr_data_ev |=> pdata == $past(wdata));
  a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
    !wr_data_ev |=> $stable(pdata));
  a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_data_ev |=> !obf_n);
  a_r4_ack_releases: assert property (@(posedge clk) disable iff (rst)
    (ack_ev && !wr_data_ev) |=> obf_n);
  a_r5_idle_ack_inert: assert property (@(posedge clk) disable iff (rst)
    (ack_ev && obf_n && !wr_data_ev && !intr) |=> !intr);
  a_r6_intr_on_release: assert property (@(posedge clk) disable iff (rst)
    (ack_ev && !obf_n && ie_q && !wr_data_ev) |=> intr);
  a_r7_write_clears_intr: assert property (@(posedge clk) disable iff (rst)
    wr_data_ev |=> !intr);
  a_r7_ie_masks_intr: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !intr);
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_data_ev && ack_ev) |=> (!obf_n && !intr));
endmodule

bind ppo_strobed_out ppo_strobed_out_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_data_ev(wr_data_ev), .bit_cmd_ev(bit_cmd_ev),
  .ack_ev(ack_ev), .ie_q(ie_q), .wdata(wdata), .pdata(pdata),
  .obf_n(obf_n), .intr(intr)
);

// File: tb/test_ppo_strobed_out.sv
`timescale 1ns/1ps
module test_ppo_strobed_out;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       ack_n = 1'b1;
  logic [7:0] pdata;
  logic       obf_n, intr;
  logic [1:0] gp_out;

  int vectors = 0;
  int miscmp  = 0;

  always #4 clk = ~clk;

  ppo_strobed_out i_ppo_strobed_out (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
    .ack_n(ack_n), .pdata(pdata), .obf_n(obf_n), .intr(intr), .gp_out(gp_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack_n = 1'b0;
    repeat (3) @(negedge clk);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  bit ie_m;
  logic [1:0] gp_m;
  logic [7:0] last;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pdata", pdata, 0);
    chk("R1 obf_n", obf_n, 1);
    chk("R1 intr", intr, 0);
    chk("R1 gp_out", gp_out, 0);
    ack_pulse();
    chk("R1 ie off (no intr)", intr, 0);

    // R2/R3 sweep all bytes, R4 ack every 32
    for (int v = 0; v < 256; v++) begin
      bus_wr(1'b1, 2'd0, 8'(v));
      chk("R2 pdata", pdata, v);
      chk("R3 obf_n low", obf_n, 0);
      if ((v % 32) == 31) begin
        ack_pulse();
        chk("R4 obf_n released", obf_n, 1);
        chk("R6 ie=0 no intr", intr, 0);
        chk("R2 pdata held", pdata, v);
      end
    end
    last = 8'hFF;

    // R10 ignored writes
    bus_wr(1'b0, 2'd0, 8'h5A);
    chk("R10 cs=0 pdata", pdata, last);
    chk("R10 cs=0 obf_n", obf_n, 1);
    bus_wr(1'b1, 2'd1, 8'h5A);
    chk("R10 ofs1 pdata", pdata, last);
    bus_wr(1'b1, 2'd2, 8'h0D);
    chk("R10 ofs2 obf_n", obf_n, 1);
    chk("R10 ofs2 gp", gp_out, 0);

    // R8 bit command sweep, IE observed through R6
    ie_m = 1'b0; gp_m = 2'b00;
    for (int idx = 0; idx < 8; idx++) begin
      for (int val = 1; val >= 0; val--) begin
        bus_wr(1'b1, 2'd3, {4'b0, 3'(idx), 1'(val)});
        if (idx == 6) ie_m = 1'(val);
        if (idx == 4) gp_m[0] = 1'(val);
        if (idx == 5) gp_m[1] = 1'(val);
        chk("R8 gp_out", gp_out, gp_m);
        bus_wr(1'b1, 2'd0, 8'(idx * 16 + val));
        chk("R7 write clears intr", intr, 0);
        ack_pulse();
        chk("R8/R6 intr follows ie", intr, ie_m);
      end
    end

    // R8 ignored command with bit7=1 (would set ie)
    bus_wr(1'b1, 2'd3, 8'h8D);
    bus_wr(1'b1, 2'd0, 8'h11);
    ack_pulse();
    chk("R8 bit7 cmd ignored", intr, 0);

    // R6 / R7 ie clear drops intr
    bus_wr(1'b1, 2'd3, 8'h0D);
    bus_wr(1'b1, 2'd0, 8'h22);
    ack_pulse();
    chk("R6 intr set", intr, 1);
    bus_wr(1'b1, 2'd3, 8'h0C);
    @(negedge clk);
    chk("R7 ie clear clears intr", intr, 0);

    // R5 ack with obf_n already high
    bus_wr(1'b1, 2'd0, 8'h33);
    ack_pulse();
    bus_wr(1'b1, 2'd3, 8'h0D);
    ack_pulse();
    chk("R5 obf_n stays", obf_n, 1);
    chk("R5 no intr", intr, 0);

    // R9 write on the same edge as ack event
    bus_wr(1'b1, 2'd0, 8'h44);
    @(negedge clk); ack_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h77;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    chk("R9 obf_n low", obf_n, 0);
    chk("R9 intr low", intr, 0);
    chk("R9 pdata new", pdata, 8'h77);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 obf_n still low", obf_n, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule